// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This block configures a register-mapped output device over a serial peripheral interface once reset is released, with no software involved. It first holds the device's hardware reset line low and lets the device recover. It then sends a software reset command. Next comes an optional link test, which writes a mirrored test bit, reads it back and checks the echo. Last, it writes a fixed list of configuration words. The supply regulator is set up before any output channel is enabled, and the output code is written last.

Each command is one 24-bit frame sent inside a single chip-select window: an address byte, then the high data byte, then the low data byte, most significant bit first. The serial clock idles low. The sequencer changes MOSI on the falling SCLK edge and samples MISO on the rising edge. The serial clock is derived from the system clock by a parameterised divider. Chip select stays high for a programmable number of SCLK periods between frames. When the sequence ends, either `seq_done` or `seq_err` asserts and remains set until the next reset.

Top module: `pwrup_cfg_seq`

## Requirements
- R1: While `rst` is high: `spi_cs_n` is 1, `spi_sclk` is 0, `dev_rst_n` is 0, and `seq_done` and `seq_err` are both 0.
- R2: After `rst` falls, `dev_rst_n` stays low for at least RST_CYC system cycles (default 4, which is 20 ns at 200 MHz). No frame starts while `dev_rst_n` is low.
- R3: A frame is exactly 24 rising SCLK edges inside one chip-select low window. Bits go out MSB first as address[7:0], data[15:8], data[7:0]. MOSI is stable while SCLK is high. SCLK is low whenever chip select is high.
- R4: The first frame is the software reset: address 0x01, data 0x0001 (word 0x010001).
- R5: With LINK_CHECK=1, the next three frames are 0x020001 (set the test bit), 0x8B0000 (read register 0x0B) and 0x000000 (no-op that clocks out the reply).
- R6: The link test passes only when bit 6 of the 24-bit word received during the no-op frame is 1. The word is received MSB first, so bit 6 is data bit 6. All other received bits are ignored.
- R7: If the link test fails, `seq_err` rises, `seq_done` stays 0, and no further frame is sent.
- R8: The configuration frames follow in this order: 0x0300F0, 0x041000, 0x06000F, 0x07061F, 0x05FFFF. Both regulator words (addresses 0x03 and 0x04) precede the channel words.
- R9: Between frames, chip select stays high for at least 2·GAP_SCLK SCLK half periods, that is 2·GAP_SCLK·CLK_DIV system cycles.
- R10: `seq_done` rises only after the chip-select rising edge of the last configuration frame. `seq_done` and `seq_err` are sticky and never both high.
- R11: Each SCLK high phase and each SCLK low phase inside a frame lasts exactly CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select, one window per frame |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device, sampled on the SCLK rise |
| dev_rst_n | output | 1 | Active-low hardware reset to the device |
| seq_done | output | 1 | Sequence completed, sticky |
| seq_err | output | 1 | Link test failed, sticky |

## Verification
The checker watches several properties on every cycle:
- the minimum length of the reset pulse and the rule that no frame starts during it;
- SCLK idling low and MOSI holding steady while SCLK is high;
- the chip-select gap between frames;
- the stickiness and mutual exclusion of the done and error flags, and silence on the bus after an error.

Other behaviour is shown only by the bench's scenarios, where a device model replies with chosen read-back words. These scenarios cover:
- the exact content and order of the frames;
- the pass/fail decision on bit 6 of the reply while all other bits are set or cleared;
- the point at which `seq_done` rises relative to the last chip-select edge.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int FRAME_W  = 24;
  localparam int ECHO_BIT = 6;

  typedef enum logic [2:0] {
    F_IDLE, F_LEAD, F_HI, F_LO, F_TAIL, F_GAP
  } frame_st_t;

  typedef enum logic [2:0] {
    S_HWRST, S_RECOV, S_ISSUE, S_WAIT, S_DONE, S_FAIL
  } seq_st_t;
endpackage

// File: rtl/pcs_tick_gen.sv
module pcs_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pcs_cmd_list.sv
module pcs_cmd_list #(
  parameter bit LINK_CHECK = 1'b1,
  parameter int IW         = 4
) (
  input  logic [IW-1:0]                idx,
  output logic [pcs_pkg::FRAME_W-1:0]  word,
  output logic                         is_check,
  output logic                         is_last
);
  localparam int N_STEPS = LINK_CHECK ? 9 : 6;

  always_comb is_last = (idx == IW'(N_STEPS - 1));

  generate
    if (LINK_CHECK) begin : g_with_link
      always_comb begin
        is_check = (idx == IW'(3));
        case (idx)
          IW'(0):  word = 24'h010001;
          IW'(1):  word = 24'h020001;
          IW'(2):  word = 24'h8B0000;
          IW'(3):  word = 24'h000000;
          IW'(4):  word = 24'h0300F0;
          IW'(5):  word = 24'h041000;
          IW'(6):  word = 24'h06000F;
          IW'(7):  word = 24'h07061F;
          default: word = 24'h05FFFF;
        endcase
      end
    end else begin : g_no_link
      always_comb begin
        is_check = 1'b0;
        case (idx)
          IW'(0):  word = 24'h010001;
          IW'(1):  word = 24'h0300F0;
          IW'(2):  word = 24'h041000;
          IW'(3):  word = 24'h06000F;
          IW'(4):  word = 24'h07061F;
          default: word = 24'h05FFFF;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/pcs_spi_frame.sv
module pcs_spi_frame #(
  parameter int W         = 24,
  parameter int GAP_TICKS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         miso,
  output logic         sclk,
  output logic         cs_n,
  output logic         mosi,
  output logic         fin,
  output logic [W-1:0] rx_word
);
  import pcs_pkg::*;
  localparam int BW = $clog2(W);
  localparam int GW = $clog2(GAP_TICKS + 1);

  frame_st_t     st;
  logic [W-1:0]  sh;
  logic [BW-1:0] bitn;
  logic [GW-1:0] gapn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      fin     <= 1'b0;
      sh      <= '0;
      rx_word <= '0;
      bitn    <= '0;
      gapn    <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          cs_n <= 1'b0;
          sh   <= tx_word;
          mosi <= tx_word[W-1];
          bitn <= '0;
          st   <= F_LEAD;
        end
        F_LEAD, F_LO: if (tick) begin
          sclk    <= 1'b1;
          rx_word <= {rx_word[W-2:0], miso};
          st      <= F_HI;
        end
        F_HI: if (tick) begin
          sclk <= 1'b0;
          if (bitn == BW'(W - 1)) begin
            st <= F_TAIL;
          end else begin
            bitn <= bitn + 1'b1;
            mosi <= sh[W-2];
            sh   <= sh << 1;
            st   <= F_LO;
          end
        end
        F_TAIL: if (tick) begin
          cs_n <= 1'b1;
          gapn <= '0;
          st   <= F_GAP;
        end
        F_GAP: if (tick) begin
          if (gapn == GW'(GAP_TICKS - 1)) begin
            fin <= 1'b1;
            st  <= F_IDLE;
          end else begin
            gapn <= gapn + 1'b1;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwrup_cfg_seq.sv
module pwrup_cfg_seq #(
  parameter int CLK_DIV    = 2,
  parameter int RST_CYC    = 4,
  parameter int GAP_SCLK   = 2,
  parameter bit LINK_CHECK = 1'b1
) (
  input  logic clk,
  input  logic rst,
  output logic spi_sclk,
  output logic spi_cs_n,
  output logic spi_mosi,
  input  logic spi_miso,
  output logic dev_rst_n,
  output logic seq_done,
  output logic seq_err
);
  import pcs_pkg::*;
  localparam int IW  = 4;
  localparam int RCW = $clog2(RST_CYC + 1);

  seq_st_t            st;
  logic [RCW-1:0]     rcnt;
  logic [IW-1:0]      idx;
  logic               tick, start, fin, is_check, is_last;
  logic [FRAME_W-1:0] word, rx_word;

  pcs_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  pcs_cmd_list #(.LINK_CHECK(LINK_CHECK), .IW(IW)) u_cmds (
    .idx(idx), .word(word), .is_check(is_check), .is_last(is_last)
  );

  pcs_spi_frame #(.W(FRAME_W), .GAP_TICKS(2 * GAP_SCLK)) u_frame (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .tx_word(word),
    .miso(spi_miso), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .fin(fin), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_HWRST;
      rcnt      <= '0;
      idx       <= '0;
      start     <= 1'b0;
      dev_rst_n <= 1'b0;
      seq_done  <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      start <= 1'b0;
      case (st)
        S_HWRST: begin
          if (rcnt == RCW'(RST_CYC - 1)) begin
            dev_rst_n <= 1'b1;
            rcnt      <= '0;
            st        <= S_RECOV;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        S_RECOV: begin
          if (rcnt == RCW'(RST_CYC - 1)) st <= S_ISSUE;
          else rcnt <= rcnt + 1'b1;
        end
        S_ISSUE: begin
          start <= 1'b1;
          st    <= S_WAIT;
        end
        S_WAIT: if (fin) begin
          if (is_check && !rx_word[ECHO_BIT]) begin
            seq_err <= 1'b1;
            st      <= S_FAIL;
          end else if (is_last) begin
            seq_done <= 1'b1;
            st       <= S_DONE;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_ISSUE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
  parameter int CLK_DIV  = 2,
  parameter int RST_CYC  = 4,
  parameter int GAP_SCLK = 2
) (
  input logic clk,
  input logic rst,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic dev_rst_n,
  input logic seq_done,
  input logic seq_err
);
  localparam int GAP_CYC = 2 * GAP_SCLK * CLK_DIV;
  logic [15:0] low_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      hi_cnt  <= '1;
    end else begin
      if (!dev_rst_n && low_cnt != '1) low_cnt <= low_cnt + 1'b1;
      if (!spi_cs_n) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R2
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_rst_n) |-> low_cnt >= 16'(RST_CYC));
  // R2
  no_frame_in_rst_chk: assert property (@(posedge clk) disable iff (rst)
    !dev_rst_n |-> spi_cs_n);
  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> $stable(spi_mosi));
  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> hi_cnt >= 16'(GAP_CYC));
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> seq_done);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(seq_done && seq_err));
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> spi_cs_n);
endmodule

bind pwrup_cfg_seq pcs_chk #(
  .CLK_DIV(CLK_DIV), .RST_CYC(RST_CYC), .GAP_SCLK(GAP_SCLK)
) u_chk (
  .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .dev_rst_n(dev_rst_n), .seq_done(seq_done),
  .seq_err(seq_err)
);

// File: tb/pwrup_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module pwrup_cfg_seq_tb_top;
  localparam int  CLK_DIV  = 2;
  localparam int  RST_CYC  = 4;
  localparam int  GAP_SCLK = 2;
  localparam time HALF_T   = CLK_DIV * 5;
  localparam time GAP_T    = 2 * GAP_SCLK * CLK_DIV * 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk, spi_cs_n, spi_mosi, dev_rst_n, seq_done, seq_err;
  logic miso_r = 1'b0;

  always #2.5 clk = ~clk;

  pwrup_cfg_seq #(.CLK_DIV(CLK_DIV), .RST_CYC(RST_CYC), .GAP_SCLK(GAP_SCLK),
                  .LINK_CHECK(1'b1)) dut_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(miso_r), .dev_rst_n(dev_rst_n),
    .seq_done(seq_done), .seq_err(seq_err)
  );

  int checks = 0;
  int fails  = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: expected frames for one run
  task automatic push_frame(logic [23:0] w, string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic push_run(bit link_ok);
    push_frame(24'h010001, "R4");
    push_frame(24'h020001, "R5");
    push_frame(24'h8B0000, "R5");
    push_frame(24'h000000, "R5");
    if (link_ok) begin
      push_frame(24'h0300F0, "R8");
      push_frame(24'h041000, "R8");
      push_frame(24'h06000F, "R8");
      push_frame(24'h07061F, "R8");
      push_frame(24'h05FFFF, "R8");
    end
  endtask

  // Device model and monitor
  logic [23:0] in_sr = '0;
  logic [23:0] out_sr = '0;
  logic [15:0] resp_data = '0;
  int  nbits = 0;
  bit  pend_rd = 0;
  bit  have_rise = 0;
  time t_sclk = 0;
  time t_cs = 0;

  always @(negedge spi_cs_n) if (!rst) begin
    chk(dev_rst_n === 1'b1, "R2", "frame start during hw reset", dev_rst_n, 1);
    if (have_rise)
      chk(($time - t_cs) >= GAP_T, "R9", "cs high gap ns", $time - t_cs, GAP_T);
    nbits  = 0;
    out_sr = pend_rd ? {8'h0B, resp_data} : 24'h0;
    miso_r = out_sr[23];
  end

  always @(posedge spi_sclk) begin
    if (spi_cs_n) chk(0, "R3", "sclk rise with cs high", 1, 0);
    else begin
      in_sr  = {in_sr[22:0], spi_mosi};
      nbits++;
      t_sclk = $time;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    chk(($time - t_sclk) == HALF_T, "R11", "sclk high ns", $time - t_sclk, HALF_T);
    out_sr = out_sr << 1;
    miso_r = out_sr[23];
  end

  always @(posedge spi_cs_n) if (!rst && nbits != 0) begin
    chk(nbits == 24, "R3", "sclk edges per frame", nbits, 24);
    if (exp_q.size() == 0) begin
      chk(0, "R7", "unexpected frame", in_sr, 0);
    end else begin
      logic [23:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(in_sr == e, t, "frame word", in_sr, e);
      if (exp_q.size() == 0)
        chk(seq_done == 1'b0, "R10", "done before last cs rise", seq_done, 0);
    end
    pend_rd   = in_sr[23];
    t_cs      = $time;
    have_rise = 1;
    nbits     = 0;
  end

  task automatic run_case(logic [15:0] resp, bit expect_ok);
    int lowc, t;
    rst       = 1'b1;
    resp_data = resp;
    pend_rd   = 0;
    have_rise = 0;
    exp_q.delete();
    tag_q.delete();
    repeat (5) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1", "sclk in reset", spi_sclk, 0);
    chk(dev_rst_n == 1'b0, "R1", "dev_rst_n in reset", dev_rst_n, 0);
    chk(seq_done == 1'b0, "R1", "done in reset", seq_done, 0);
    chk(seq_err == 1'b0, "R1", "err in reset", seq_err, 0);
    push_run(expect_ok);
    rst  = 1'b0;
    lowc = 0;
    while (!dev_rst_n && lowc < 1000) begin
      @(negedge clk);
      lowc++;
    end
    chk(lowc >= RST_CYC, "R2", "hw reset low cycles", lowc, RST_CYC);
    t = 0;
    while (!seq_done && !seq_err && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (expect_ok) begin
      chk(seq_done == 1'b1, "R6", "done after good echo", seq_done, 1);
      chk(seq_err == 1'b0, "R6", "err after good echo", seq_err, 0);
    end else begin
      chk(seq_err == 1'b1, "R7", "err after bad echo", seq_err, 1);
      chk(seq_done == 1'b0, "R7", "done after bad echo", seq_done, 0);
    end
    repeat (1000) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "frames left unsent", exp_q.size(), 0);
    chk(seq_done == expect_ok, "R10", "done sticky", seq_done, expect_ok);
    chk(seq_err == !expect_ok, "R10", "err sticky", seq_err, !expect_ok);
    chk(spi_cs_n == 1'b1, "R7", "bus idle at end", spi_cs_n, 1);
  endtask

  initial begin
    run_case(16'h0040, 1'b1);  // R6: only bit 6 set
    run_case(16'hFFBF, 1'b0);  // R6 R7: every bit but 6 set
    run_case(16'hFFFF, 1'b1);  // R6: all bits set
    run_case(16'h0000, 1'b0);  // R7: silent device
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule